// File: doc/BRIEF.md
# IEC 60958 Transmit Channel Status Bank

This block keeps the channel status that a host programs for an IEC 60958 transmitter. It returns the single status bit that belongs to each outgoing subframe. The host writes 40 status bits for the left channel and 40 for the right channel, one byte per write. The bits go into a staging copy. The encoder only ever reads a separate active copy. The active copy, together with a copy-mode flag, is reloaded from staging at a block start, and only while the host's valid flag is set. Contents therefore never change in the middle of a block, and never while the host is still rewriting them.

For each subframe the encoder presents three things: the frame index within the 192-frame block, a flag that is high for the right channel, and a strobe that is high on the first frame of a block. One clock later, the block returns the status bit for that frame. When copy mode is active, right-channel subframes carry the left channel's bits.

The host is expected to follow this sequence:
1. Clear valid.
2. Choose the copy mode.
3. Write the ten bytes.
4. Set valid again.

Top module: `tx_chstat_bank`

## Requirements
- R1: After reset, every staging bit, every active bit and both control flags are 0, and `cs_bit` is 0.
- R2: The host address map is as follows. Addresses 0..4 hold the left channel bytes and 5..9 hold the right channel bytes, least significant byte first: the byte at offset k holds status bits 8k..8k+7. Address 10 is control: bit 0 is valid and bit 1 is copy. Status bit n of a channel is sent in the subframe with frame index n.
- R3: `cs_bit` is registered. The bit for the request presented at one rising edge appears after that edge and holds until the next edge.
- R4: When the active copy flag is 1, right-channel subframes carry the left channel's active bits.
- R5: A block start seen while valid is 0 leaves the active copy unchanged, so host writes made then do not reach `cs_bit`.
- R6: New staging contents are used from the next block start with valid at 1, including in that start frame itself. Writes made in the middle of a block do not change the rest of that block.
- R7: Frame indices 40 to 191 return a status bit of 0 on both channels.
- R8: A change of copy mode, like a change of bits, takes effect only at a block start with valid at 1.
- R9: Writes to addresses 11..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 4 | Host word address |
| host_wdata | input | 8 | Host write byte |
| blk_start | input | 1 | High on the first frame of a block |
| chan_right | input | 1 | Request is for the right-channel subframe |
| frm_idx | input | 8 | Frame index within the block, 0..191 |
| cs_bit | output | 1 | Status bit for the requested subframe, one cycle later |

## Verification
The bench first checks that a block start with no valid flag leaves the output at zero. It then looks at the block-start frame itself. There, a design that loaded a cycle late would send the old bit 0 while the new block began. Mid-block rewrites of bits and of copy mode are checked too. A design that bypassed the active copy would change bits partway through a block, or switch the right channel to left data early. Further tests write with valid cleared, probe indices past 39, where a design with a missed range guard would send aliased bits, and write to unmapped addresses, where a loose decoder would overwrite a byte or the control flags.

// File: rtl/tx_chstat_bank.sv
module tx_chstat_bank #(
  parameter int CS_BITS = 40,
  parameter int FRAMES  = 192,
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             blk_start,
  input  logic             chan_right,
  input  logic [IDX_W-1:0] frm_idx,
  output logic             cs_bit
);
  localparam int NB        = CS_BITS / DW;
  localparam int CTRL_ADDR = 2 * NB;
  localparam int BI_W      = $clog2(CS_BITS);

  logic [CS_BITS-1:0] stg_l, stg_r, act_l, act_r;
  logic               stg_valid, stg_copy, act_copy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_l     <= '0;
      stg_r     <= '0;
      stg_valid <= 1'b0;
      stg_copy  <= 1'b0;
    end else if (host_we) begin
      for (int b = 0; b < NB; b++) begin
        if (int'(host_addr) == b)      stg_l[b*DW +: DW] <= host_wdata;
        if (int'(host_addr) == NB + b) stg_r[b*DW +: DW] <= host_wdata;
      end
      if (int'(host_addr) == CTRL_ADDR) begin
        stg_valid <= host_wdata[0];
        stg_copy  <= host_wdata[1];
      end
    end
  end

  logic               load, in_rng, nxt_copy;
  logic [CS_BITS-1:0] nxt_l, nxt_r, sel;

  assign load     = blk_start && stg_valid;
  assign nxt_l    = load ? stg_l : act_l;
  assign nxt_r    = load ? stg_r : act_r;
  assign nxt_copy = load ? stg_copy : act_copy;
  assign in_rng   = int'(frm_idx) < CS_BITS;
  assign sel      = (chan_right && !nxt_copy) ? nxt_r : nxt_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_l    <= '0;
      act_r    <= '0;
      act_copy <= 1'b0;
      cs_bit   <= 1'b0;
    end else begin
      act_l    <= nxt_l;
      act_r    <= nxt_r;
      act_copy <= nxt_copy;
      cs_bit   <= in_rng ? sel[frm_idx[BI_W-1:0]] : 1'b0;
    end
  end
endmodule

module tx_chstat_chk #(
  parameter int CS_BITS = 40,
  parameter int IDX_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               blk_start,
  input logic               chan_right,
  input logic [IDX_W-1:0]   frm_idx,
  input logic               cs_bit,
  input logic               stg_valid,
  input logic [CS_BITS-1:0] stg_l,
  input logic [CS_BITS-1:0] act_l,
  input logic [CS_BITS-1:0] act_r,
  input logic               act_copy
);
  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |=> !cs_bit);

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(frm_idx) >= CS_BITS) |=> !cs_bit);

  assert_hold_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !stg_valid) |=> ($stable(act_l) && $stable(act_r) && $stable(act_copy)));

  assert_midblock_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> ($stable(act_l) && $stable(act_r) && $stable(act_copy)));

  assert_load_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && stg_valid) |=> (act_l == $past(stg_l)));

  assert_copy_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_start && chan_right && act_copy && int'(frm_idx) < CS_BITS)
      |=> (cs_bit == $past(act_l[frm_idx])));
endmodule

bind tx_chstat_bank tx_chstat_chk #(.CS_BITS(CS_BITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .chan_right(chan_right),
  .frm_idx(frm_idx), .cs_bit(cs_bit), .stg_valid(stg_valid), .stg_l(stg_l),
  .act_l(act_l), .act_r(act_r), .act_copy(act_copy)
);

// File: tb/sim_tx_chstat_bank.sv
`timescale 1ns/1ps
module sim_tx_chstat_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       blk_start = 1'b0;
  logic       chan_right = 1'b0;
  logic [7:0] frm_idx = '0;
  logic       cs_bit;

  always #2 clk = ~clk;

  tx_chstat_bank u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .blk_start(blk_start), .chan_right(chan_right),
    .frm_idx(frm_idx), .cs_bit(cs_bit)
  );

  localparam logic [11:0] PROG [12] = '{
    {4'd10, 8'h00}, {4'd0, 8'hA5}, {4'd1, 8'h3C}, {4'd2, 8'h0F},
    {4'd3, 8'h81},  {4'd4, 8'hE7}, {4'd5, 8'h5A}, {4'd6, 8'hC3},
    {4'd7, 8'hF0},  {4'd8, 8'h18}, {4'd9, 8'h7E}, {4'd10, 8'h01}
  };

  int checks = 0, fails = 0;
  bit done = 0;
  logic [39:0] ml = '0, mr = '0, al = '0, ar = '0;
  bit mvalid = 0, mcopy = 0, acopy = 0;

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    ml = '0; mr = '0; al = '0; ar = '0; mvalid = 0; mcopy = 0; acopy = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    if (a < 5) ml[a*8 +: 8] = d;
    else if (a < 10) mr[(a-5)*8 +: 8] = d;
    else if (a == 10) begin mvalid = d[0]; mcopy = d[1]; end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic q(input int idx, input bit right, input bit blk, input string tag);
    logic [39:0] sl, sr;
    bit sc;
    logic e;
    @(negedge clk);
    frm_idx = 8'(idx); chan_right = right; blk_start = blk;
    sl = (blk && mvalid) ? ml : al;
    sr = (blk && mvalid) ? mr : ar;
    sc = (blk && mvalid) ? mcopy : acopy;
    e = (idx < 40) ? ((right && !sc) ? sr[idx] : sl[idx]) : 1'b0;
    if (blk && mvalid) begin al = ml; ar = mr; acopy = mcopy; end
    @(negedge clk);
    blk_start = 1'b0;
    chk(cs_bit, e, tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_bit, 1'b0, "R1 output in reset");
    rst_n = 1'b1;
    q(0, 0, 1, "R1 no load without valid");
    wr(4'd10, 8'h01);
    for (int i = 0; i < 40; i++) q(i, i[0], i == 0, "R1 reset bits zero");

    foreach (PROG[k]) wr(PROG[k][11:8], PROG[k][7:0]);
    q(0, 0, 0, "R6 mid-block left unchanged");
    q(0, 0, 1, "R6 start frame uses new bits");
    for (int i = 1; i < 40; i++) begin
      q(i, 0, 0, "R2 left bit map");
      q(i, 1, 0, "R2 right bit map");
    end
    q(40, 0, 0, "R7 idx 40 left");
    q(100, 1, 0, "R7 idx 100 right");
    q(191, 0, 0, "R7 idx 191 left");

    @(negedge clk);
    frm_idx = 8'd0; chan_right = 1'b0;
    @(negedge clk);
    frm_idx = 8'd1;
    #1 chk(cs_bit, ml[0], "R3 holds until edge");
    @(negedge clk);
    chk(cs_bit, ml[1], "R3 updates after edge");

    wr(4'd10, 8'h03);
    q(3, 1, 0, "R8 copy waits for block start");
    q(3, 1, 1, "R4 copy at start frame");
    for (int i = 4; i < 12; i++) q(i, 1, 0, "R4 right carries left");

    wr(4'd10, 8'h00);
    wr(4'd0, 8'h5A);
    wr(4'd5, 8'hFF);
    q(0, 0, 1, "R5 invalid start keeps old left");
    q(1, 1, 0, "R5 invalid keeps copy");
    wr(4'd10, 8'h01);
    q(1, 1, 0, "R6 mid-block after valid");
    q(0, 0, 1, "R6 new left at start");
    q(1, 1, 0, "R6 right own bits");

    wr(4'd12, 8'h00);
    wr(4'd15, 8'hFF);
    wr(4'd11, 8'h02);
    q(2, 0, 1, "R9 unmapped left");
    q(2, 1, 0, "R9 unmapped right");
    for (int i = 0; i < 8; i++) q(i, 1, 0, "R9 right intact");

    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk(cs_bit, 1'b0, "R1 async reset output");
    rst_n = 1'b1;
    wr(4'd10, 8'h01);
    q(0, 0, 1, "R1 left cleared");
    q(2, 1, 0, "R1 right cleared");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule